// File: doc/BRIEF.md
# Vector Indexed Scatter Store Unit

This block takes a single vector store request and spreads its lanes across a byte-addressed on-chip buffer. Each request carries the following:

- a vector of up to `LANES` elements;
- a per-lane integer index vector;
- a base byte address;
- an element size code;
- an active-lane count.

The count enables lanes as a prefix: lanes `0 .. count-1` take part, and a count above `LANES` is clamped to `LANES`. Each lane's byte address is the base plus its index times the element width in bytes. The writes then go out one lane per cycle through a single 32-bit word write port, with byte enables.

Legality is checked over the whole request before any write is issued. A bad size code, a misaligned address or an address outside the buffer on any active lane makes the request fail as a whole. In that case no write is issued, and the error flag is raised together with the one-cycle done pulse. When active lanes collide on the same address, only the lowest-numbered lane writes and the others are skipped.

The controller is a four-state machine:

- **S_IDLE**: `req_ready` is high. On `req_valid` the request is latched, and the machine takes the *accept* transition to **S_CHECK**.
- **S_CHECK**: lasts one cycle and evaluates legality. It takes the *fail* transition to **S_DONE** on error, the *empty* transition to **S_DONE** when the count is zero, and the *start* transition to **S_WRITE** otherwise.
- **S_WRITE**: visits one lane per cycle, in ascending order. It takes the *next* transition to the following lane, and the *last* transition to **S_DONE** after lane count-1.
- **S_DONE**: pulses `done` for one cycle, then takes the *release* transition back to **S_IDLE**.

Top module: `vscatter_unit`

## Requirements
- R1: After reset `req_ready`=1, `wr_en`=0 and `done`=0. `req_ready` is high only in S_IDLE, and a request is taken when `req_valid` and `req_ready` are both high at a rising clock edge.
- R2: Size code 0 selects 1-byte elements, 1 selects 2-byte elements and 2 selects 4-byte elements. Code 3 is illegal: the request ends with `err`=1 and issues no write.
- R3: A lane's byte address A is `req_base + idx*bytes`. Its write uses `wr_word`=A[ADDR_W-1:2]. For 1-byte elements, `wr_be` is 1<<A[1:0] and `wr_data` is the low byte repeated four times. For 2-byte elements, `wr_be` is 3<<A[1:0] and `wr_data` is the low half-word repeated twice. For 4-byte elements, `wr_be` is 4'hF and `wr_data` is the whole lane.
- R4: Only lanes below the active count write. A count above `LANES` behaves as `LANES`.
- R5: A count of zero gives no writes and a done pulse with `err`=0, two cycles after acceptance.
- R6: If any active lane's address is not a multiple of the element size, the request issues no write and ends with `err`=1.
- R7: If any active lane's address is at or beyond `MEM_BYTES`, the request issues no write and ends with `err`=1.
- R8: Among active lanes with equal addresses, only the lowest-numbered lane writes.
- R9: After one check cycle, lane k occupies cycle k of the write phase, in ascending order, whether or not that lane writes. `done` follows the last lane and lasts exactly one cycle.
- R10: At most one write is issued per cycle, and none while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_size | input | 2 | Element size code (0: 8, 1: 16, 2: 32 bits) |
| req_base | input | ADDR_W | Base byte address |
| req_data | input | LANES*32 | Lane elements, lane i in bits [32i+31:32i], element in the low bits |
| req_idx | input | LANES*IDX_W | Unsigned lane indices, lane i in bits [IDX_W*i+IDX_W-1:IDX_W*i] |
| req_count | input | CNT_W | Number of active leading lanes |
| wr_en | output | 1 | Buffer write strobe |
| wr_word | output | ADDR_W-2 | Buffer word address |
| wr_be | output | 4 | Byte enables within the word |
| wr_data | output | 32 | Write data, placed by byte lane |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected; valid with done |

## Verification
A wrong state register or lane pointer would show within one cycle at the ports, in several ways:

- a missing or extra `wr_en` pulse;
- writes in a shifted lane order;
- `done` arriving a cycle early or late.

The bench predicts each of these cycle by cycle from the request alone. A stale legality verdict would surface on the done cycle, as a mismatched `err`. It would also appear as writes in a request that should have been rejected.

A faulty alias comparison would surface at the lane's own write-phase cycle, as an unexpected strobe on a duplicate address, or a missing strobe on the first lane to use that address.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } vsc_state_e;

    localparam logic [1:0] SZ_B8  = 2'd0;
    localparam logic [1:0] SZ_B16 = 2'd1;
    localparam logic [1:0] SZ_B32 = 2'd2;
    localparam logic [1:0] SZ_BAD = 2'd3;

    localparam int ELEM_W = 32;
endpackage

// File: rtl/vsc_addr_gen.sv
module vsc_addr_gen
    import vsc_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int IDX_W     = 16,
    parameter int MEM_BYTES = 4096,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int SUM_W    = ((ADDR_W > IDX_W) ? ADDR_W : IDX_W) + 4
) (
    input  logic [ADDR_W-1:0]       base,
    input  logic [LANES*IDX_W-1:0]  idx,
    input  logic [1:0]              size,
    output logic [LANES*ADDR_W-1:0] addr,
    output logic [LANES-1:0]        lane_ok
);
    logic [SUM_W-1:0] align_mask;
    assign align_mask = (SUM_W'(1) << size) - SUM_W'(1);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SUM_W-1:0] full;
        assign full = SUM_W'(base) + (SUM_W'(idx[i*IDX_W +: IDX_W]) << size);
        assign addr[i*ADDR_W +: ADDR_W] = full[ADDR_W-1:0];
        assign lane_ok[i] = (full < SUM_W'(MEM_BYTES)) && ((full & align_mask) == '0);
    end
endmodule

// File: rtl/vsc_lane_pick.sv
module vsc_lane_pick
    import vsc_pkg::*;
#(
    parameter int LANES   = 8,
    parameter int ADDR_W  = 12,
    localparam int PTR_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES*ELEM_W-1:0] data,
    input  logic [1:0]              size,
    input  logic [PTR_W-1:0]        ptr,
    output logic                    dup,
    output logic [ADDR_W-3:0]       word,
    output logic [3:0]              be,
    output logic [ELEM_W-1:0]       wdata
);
    logic [ADDR_W-1:0] cur;
    logic [ELEM_W-1:0] elem;

    assign cur  = addr[ptr*ADDR_W +: ADDR_W];
    assign elem = data[ptr*ELEM_W +: ELEM_W];
    assign word = cur[ADDR_W-1:2];

    always_comb begin
        dup = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            if (j < int'(ptr) && addr[j*ADDR_W +: ADDR_W] == cur) dup = 1'b1;
        end
    end

    always_comb begin
        unique case (size)
            SZ_B8: begin
                be    = 4'b0001 << cur[1:0];
                wdata = {4{elem[7:0]}};
            end
            SZ_B16: begin
                be    = 4'b0011 << cur[1:0];
                wdata = {2{elem[15:0]}};
            end
            default: begin
                be    = 4'b1111;
                wdata = elem;
            end
        endcase
    end
endmodule

// File: rtl/vscatter_unit.sv
module vscatter_unit
    import vsc_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int IDX_W     = 16,
    parameter int MEM_BYTES = 4096,
    parameter int CNT_W     = 8,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int LCNT_W   = $clog2(LANES + 1),
    localparam int PTR_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [1:0]              req_size,
    input  logic [ADDR_W-1:0]       req_base,
    input  logic [LANES*ELEM_W-1:0] req_data,
    input  logic [LANES*IDX_W-1:0]  req_idx,
    input  logic [CNT_W-1:0]        req_count,
    output logic                    wr_en,
    output logic [ADDR_W-3:0]       wr_word,
    output logic [3:0]              wr_be,
    output logic [ELEM_W-1:0]       wr_data,
    output logic                    done,
    output logic                    err
);
    vsc_state_e               state_q;
    logic [1:0]               size_q;
    logic [ADDR_W-1:0]        base_q;
    logic [LANES*ELEM_W-1:0]  data_q;
    logic [LANES*IDX_W-1:0]   idx_q;
    logic [LCNT_W-1:0]        cnt_q;
    logic [PTR_W-1:0]         ptr_q;
    logic                     err_q;

    logic [LANES*ADDR_W-1:0]  lane_addr;
    logic [LANES-1:0]         lane_ok;
    logic [LANES-1:0]         active;
    logic                     bad_req;
    logic                     lane_dup;
    logic                     last_lane;

    vsc_addr_gen #(.LANES(LANES), .IDX_W(IDX_W), .MEM_BYTES(MEM_BYTES)) u_addr (
        .base(base_q), .idx(idx_q), .size(size_q),
        .addr(lane_addr), .lane_ok(lane_ok)
    );

    vsc_lane_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) u_pick (
        .addr(lane_addr), .data(data_q), .size(size_q), .ptr(ptr_q),
        .dup(lane_dup), .word(wr_word), .be(wr_be), .wdata(wr_data)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_act
        assign active[i] = (LCNT_W'(i) < cnt_q);
    end

    assign bad_req   = (size_q == SZ_BAD) || (|(active & ~lane_ok));
    assign last_lane = ((LCNT_W'(ptr_q) + LCNT_W'(1)) == cnt_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            size_q  <= SZ_B8;
            base_q  <= '0;
            data_q  <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            ptr_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        size_q  <= req_size;
                        base_q  <= req_base;
                        data_q  <= req_data;
                        idx_q   <= req_idx;
                        cnt_q   <= (req_count > CNT_W'(LANES)) ? LCNT_W'(LANES)
                                                               : LCNT_W'(req_count);
                        ptr_q   <= '0;
                        err_q   <= 1'b0;
                        state_q <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    err_q   <= bad_req;
                    state_q <= (bad_req || cnt_q == '0) ? S_DONE : S_WRITE;
                end
                S_WRITE: begin
                    if (last_lane) begin
                        ptr_q   <= '0;
                        state_q <= S_DONE;
                    end else begin
                        ptr_q <= ptr_q + PTR_W'(1);
                    end
                end
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = 1'b0;
        wr_en     = 1'b0;
        done      = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            S_IDLE:  req_ready = 1'b1;
            S_CHECK: ;
            S_WRITE: wr_en = !lane_dup;
            S_DONE: begin
                done = 1'b1;
                err  = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vsc_checker.sv
module vsc_checker #(
    parameter int LANES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       wr_en,
    input logic [3:0] wr_be,
    input logic       done,
    input logic       err
);
    logic [15:0] wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_seen <= '0;
        else if (req_valid && req_ready) wr_seen <= '0;
        else if (wr_en) wr_seen <= wr_seen + 16'd1;
    end

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_be_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_be == 4'h1 || wr_be == 4'h2 || wr_be == 4'h4 || wr_be == 4'h8 ||
                   wr_be == 4'h3 || wr_be == 4'hC || wr_be == 4'hF));

    p_write_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_seen <= 16'(LANES)));

    p_err_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (wr_seen == 16'd0));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_no_write_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wr_en);

    p_err_only_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
endmodule

bind vscatter_unit vsc_checker #(.LANES(LANES)) u_vsc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .wr_en(wr_en), .wr_be(wr_be), .done(done), .err(err)
);

// File: tb/vscatter_unit_tb.sv
module vscatter_unit_tb;
    localparam int LANES = 8;
    localparam int IDX_W = 16;
    localparam int MEM   = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_size = 2'd0;
    logic [11:0] req_base = '0;
    logic [LANES*32-1:0] req_data = '0;
    logic [LANES*IDX_W-1:0] req_idx = '0;
    logic [7:0] req_count = '0;
    logic wr_en;
    logic [9:0] wr_word;
    logic [3:0] wr_be;
    logic [31:0] wr_data;
    logic done, err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [31:0] d [LANES];
    int ix [LANES];

    always #5 clk = ~clk;

    vscatter_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_base(req_base), .req_data(req_data),
        .req_idx(req_idx), .req_count(req_count), .wr_en(wr_en), .wr_word(wr_word),
        .wr_be(wr_be), .wr_data(wr_data), .done(done), .err(err)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_req(string tag, int sz, int base, int count);
        int bytes, cnt, a;
        bit bad;
        int full [LANES];
        for (int i = 0; i < LANES; i++) begin
            req_data[i*32 +: 32] = d[i];
            req_idx[i*IDX_W +: IDX_W] = IDX_W'(ix[i]);
        end
        req_size = 2'(sz);
        req_base = 12'(base);
        req_count = 8'(count);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        bytes = 1 << sz;
        cnt = (count > LANES) ? LANES : count;
        bad = (sz == 3);
        for (int i = 0; i < cnt; i++) begin
            full[i] = base + ix[i] * bytes;
            if ((full[i] % bytes) != 0 || full[i] >= MEM) bad = 1;
        end
        chk({tag, " R1 busy in check"}, 32'(req_ready), 0);
        chk({tag, " R9 no write in check"}, 32'(wr_en), 0);
        if (!bad) begin
            for (int i = 0; i < cnt; i++) begin
                bit dupl;
                logic [31:0] ed;
                logic [3:0] eb;
                @(negedge clk);
                dupl = 0;
                for (int j = 0; j < i; j++) if (full[j] == full[i]) dupl = 1;
                a = full[i];
                chk({tag, " R8 R9 R4 wr_en lane"}, 32'(wr_en), 32'(!dupl));
                chk({tag, " R9 no done in write"}, 32'(done), 0);
                if (!dupl) begin
                    if (sz == 0) begin
                        ed = {4{d[i][7:0]}}; eb = 4'(1 << (a % 4));
                    end else if (sz == 1) begin
                        ed = {2{d[i][15:0]}}; eb = 4'(3 << (a % 4));
                    end else begin
                        ed = d[i]; eb = 4'hF;
                    end
                    chk({tag, " R3 word"}, 32'(wr_word), 32'(a / 4));
                    chk({tag, " R3 be"}, 32'(wr_be), 32'(eb));
                    chk({tag, " R3 data"}, wr_data, ed);
                end
            end
        end
        @(negedge clk);
        chk({tag, " R9 done"}, 32'(done), 1);
        chk({tag, " R2 R6 R7 err"}, 32'(err), 32'(bad));
        chk({tag, " R10 no write at done"}, 32'(wr_en), 0);
        @(negedge clk);
        chk({tag, " R9 done pulse ends"}, 32'(done), 0);
        chk({tag, " R1 ready again"}, 32'(req_ready), 1);
    endtask

    initial begin
        #1;
        chk("R1 reset ready", 32'(req_ready), 1);
        chk("R1 reset wr_en", 32'(wr_en), 0);
        chk("R1 reset done", 32'(done), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < LANES; i++) begin d[i] = 32'hA000_0000 + 32'(i * 17); ix[i] = i; end
        run_req("R3 size32 linear", 2, 12'h100, 8);

        for (int i = 0; i < LANES; i++) begin d[i] = 32'h1234_5600 + 32'(i); ix[i] = i * 3 + 1; end
        run_req("R3 size8 mixed bytes", 0, 12'h201, 5);

        for (int i = 0; i < LANES; i++) begin d[i] = 32'hBEEF_0000 + 32'(i); ix[i] = 7 - i; end
        run_req("R4 size16 count clamp", 1, 12'h040, 20);

        run_req("R4 partial count", 2, 12'h000, 3);
        run_req("R5 zero count", 2, 12'h000, 0);
        run_req("R2 bad size code", 3, 12'h000, 4);
        run_req("R6 misaligned 32", 2, 12'h102, 2);
        run_req("R6 misaligned 16", 1, 12'h011, 1);

        for (int i = 0; i < LANES; i++) ix[i] = i;
        ix[4] = 4;
        run_req("R7 range edge ok", 2, 12'hFE0, 8);
        ix[3] = 8;
        run_req("R7 out of range", 2, 12'hFE0, 8);
        ix[3] = 3; ix[6] = 500;
        run_req("R4 inactive lane far", 2, 12'hFE0, 6);

        ix[0] = 3; ix[1] = 5; ix[2] = 3; ix[3] = 3; ix[4] = 7; ix[5] = 5; ix[6] = 0; ix[7] = 7;
        for (int i = 0; i < LANES; i++) d[i] = 32'h0000_C000 + 32'(i);
        run_req("R8 alias size16", 1, 12'h300, 8);
        run_req("R8 alias size8", 0, 12'h302, 8);

        report();
    end
endmodule